// File: doc/BRIEF.md
# Recent-Address Hazard Gate

This block guards the entry of a pipelined hash table against read-after-write hazards. Each request carries two precomputed table addresses. The gate keeps a small first-in first-out window of the address pairs that belong to requests it has already let through and that the downstream pipeline has not yet finished. Each incoming pair is compared exactly against every pair in the window. Because the comparison is exact, two different addresses never count as a conflict, so false stalls stay rare.

When no address overlaps and the window has room, the request goes downstream in the same cycle it is presented, so back-to-back traffic keeps full throughput. When an address overlaps, or the window is full, the request is held with `reqReady` low until completions clear the way. Completions come back in issue order. Each `doneStrobe` pulse therefore retires the oldest window entry.

Top module: `addr_hazard_gate`

## Requirements
- R1: After reset the window is empty: with `reqValid` low, `reqReady` is 1 and both `stallConflict` and `stallFull` are 0.
- R2: A request whose two addresses match nothing in the window, while the window is not full, is accepted in the same cycle: `reqReady` is 1 and `issueValid` is 1. The request's pair then enters the window.
- R3: A request is held (`reqReady` 0, `issueValid` 0, `stallConflict` 1) when its first address equals either stored address of any valid entry.
- R4: A request is also held when its second address equals either stored address of any valid entry. This includes cross matches, where the second address equals a stored first address.
- R5: A held request is accepted in the first cycle after the completion that retires the last conflicting entry.
- R6: When the window holds DEPTH entries, every new request is held with `stallFull` 1, even with no address overlap.
- R7: Each `doneStrobe` pulse retires only the oldest entry. Conflicts with entries that are newer than the retired one still hold requests.
- R8: A `doneStrobe` pulse while the window is empty has no effect. Afterwards DEPTH requests are still accepted before `stallFull` rises.
- R9: A request that is presented in the same cycle as the completion retiring its conflicting entry is still held in that cycle.
- R10: The window depth is the parameter DEPTH (default 8). The address width is ADDR_W (default 16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is presented |
| reqAddrA | input | ADDR_W | First table address of the request |
| reqAddrB | input | ADDR_W | Second table address of the request |
| doneStrobe | input | 1 | Oldest in-flight request has completed |
| reqReady | output | 1 | Request may proceed this cycle |
| issueValid | output | 1 | Request is passed downstream this cycle |
| stallConflict | output | 1 | Held because an address overlaps the window |
| stallFull | output | 1 | Held because the window is full |

## Verification
Corrupted window state shows up at the ports within one request. A valid bit that is stuck or cleared lets a conflicting address through (`issueValid` rises where a hold is expected), or it holds a request that should pass. A wrong occupancy count or pointer shows up as `stallFull` asserting too early or too late when the window is filled from empty. It also shows up as the wrong entry being retired, which the ordered-retirement and cross-match scenarios expose on the next presented request.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef struct packed {
    logic push;
    logic pop;
  } hzStrobe_t;
endpackage

// File: rtl/hazard_dp.sv
module hazard_dp
  import hazard_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hzStrobe_t         strobe,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  rdPtr,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [ADDR_W-1:0] addrB,
  output logic              hit
);
  logic [ADDR_W-1:0] slotA [DEPTH];
  logic [ADDR_W-1:0] slotB [DEPTH];
  logic [DEPTH-1:0]  slotValid;
  logic [DEPTH-1:0]  slotMatch;

  genvar i;
  generate
    for (i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          slotValid[i] <= 1'b0;
        end else if (strobe.push && wrPtr == PTR_W'(i)) begin
          slotValid[i] <= 1'b1;
        end else if (strobe.pop && rdPtr == PTR_W'(i)) begin
          slotValid[i] <= 1'b0;
        end
      end

      always_ff @(posedge clk) begin
        if (strobe.push && wrPtr == PTR_W'(i)) begin
          slotA[i] <= addrA;
          slotB[i] <= addrB;
        end
      end

      assign slotMatch[i] = slotValid[i] &&
        (addrA == slotA[i] || addrA == slotB[i] ||
         addrB == slotA[i] || addrB == slotB[i]);
    end
  endgenerate

  assign hit = |slotMatch;
endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
  import hazard_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic             doneStrobe,
  input  logic             hit,
  output hzStrobe_t        strobe,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic [CNT_W-1:0] windowCount,
  output logic             full,
  output logic             ready
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  assign full        = (windowCount == CNT_W'(DEPTH));
  assign ready       = !full && !hit;
  assign strobe.push = reqValid && ready;
  assign strobe.pop  = doneStrobe && (windowCount != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr       <= '0;
      rdPtr       <= '0;
      windowCount <= '0;
    end else begin
      if (strobe.push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({strobe.push, strobe.pop})
        2'b10:   windowCount <= windowCount + 1'b1;
        2'b01:   windowCount <= windowCount - 1'b1;
        default: windowCount <= windowCount;
      endcase
    end
  end
endmodule

// File: rtl/addr_hazard_gate.sv
module addr_hazard_gate
  import hazard_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddrA,
  input  logic [ADDR_W-1:0] reqAddrB,
  input  logic              doneStrobe,
  output logic              reqReady,
  output logic              issueValid,
  output logic              stallConflict,
  output logic              stallFull
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  hzStrobe_t        strobe;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [CNT_W-1:0] windowCount;
  logic             hit;
  logic             full;

  hazard_ctl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .doneStrobe(doneStrobe),
    .hit(hit), .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .windowCount(windowCount), .full(full), .ready(reqReady)
  );

  hazard_dp #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .addrA(reqAddrA), .addrB(reqAddrB), .hit(hit)
  );

  assign issueValid    = strobe.push;
  assign stallConflict = hit;
  assign stallFull     = full;
endmodule

// File: rtl/hazard_window_chk.sv
module hazard_window_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reqValid,
  input logic             issueValid,
  input logic             stallConflict,
  input logic             stallFull,
  input logic             doneStrobe,
  input logic [CNT_W-1:0] occupancy
);
  assert_conflict_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stallConflict |-> !issueValid);

  assert_full_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stallFull |-> !issueValid);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= CNT_W'(DEPTH));

  assert_issue_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (issueValid && !doneStrobe) |=> occupancy == $past(occupancy) + 1'b1);

  assert_issue_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issueValid |-> reqValid);

  assert_empty_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == '0 && doneStrobe && !issueValid) |=> occupancy == '0);

  assert_done_retires_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy != '0 && doneStrobe && !issueValid) |=> occupancy == $past(occupancy) - 1'b1);
endmodule

bind addr_hazard_gate hazard_window_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .issueValid(issueValid),
  .stallConflict(stallConflict), .stallFull(stallFull),
  .doneStrobe(doneStrobe), .occupancy(windowCount)
);

// File: tb/addr_hazard_gate_tb.sv
module addr_hazard_gate_tb;
  localparam int DEPTH  = 8;
  localparam int ADDR_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddrA = '0;
  logic [ADDR_W-1:0] reqAddrB = '0;
  logic doneStrobe = 1'b0;
  logic reqReady, issueValid, stallConflict, stallFull;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  addr_hazard_gate #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAddrA(reqAddrA),
    .reqAddrB(reqAddrB), .doneStrobe(doneStrobe), .reqReady(reqReady),
    .issueValid(issueValid), .stallConflict(stallConflict), .stallFull(stallFull)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Drive one cycle on the falling edge, check before the rising edge.
  task automatic step(input logic v, input int a, input int b, input logic d,
                      input logic expIssue, input string tag);
    @(negedge clk);
    reqValid   = v;
    reqAddrA   = ADDR_W'(a);
    reqAddrB   = ADDR_W'(b);
    doneStrobe = d;
    #1;
    chk(tag, issueValid, expIssue);
    chk(tag, reqReady, expIssue | !v ? reqReady : 1'b0);
    @(posedge clk);
    #1;
    reqValid = 1'b0;
    doneStrobe = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    #1;
    chk("R1 ready", reqReady, 1'b1);
    chk("R1 conflict", stallConflict, 1'b0);
    chk("R1 full", stallFull, 1'b0);
  endtask

  task automatic t_pass();
    step(1, 1, 2, 0, 1, "R2 first accept");
    step(1, 3, 4, 0, 1, "R2 second accept");
  endtask

  task automatic t_conflict();
    @(negedge clk);
    reqValid = 1; reqAddrA = 16'd1; reqAddrB = 16'd7; #1;
    chk("R3 A matches stored A", issueValid, 1'b0);
    chk("R3 stallConflict", stallConflict, 1'b1);
    step(1, 2, 9, 0, 0, "R3 A matches stored B");
    step(1, 5, 4, 0, 0, "R4 B matches stored B");
    step(1, 9, 3, 0, 0, "R4 B matches stored A cross");
  endtask

  task automatic t_same_cycle_done();
    step(1, 9, 2, 1, 0, "R9 held in retiring cycle");
    step(1, 9, 2, 0, 1, "R5 accepted after retire");
  endtask

  task automatic t_order();
    // window now {3,4},{9,2}
    step(0, 0, 0, 1, 0, "R7 retire oldest");
    step(1, 3, 10, 0, 1, "R7 retired entry no longer blocks");
    step(1, 2, 11, 0, 0, "R7 newer entry still blocks");
  endtask

  task automatic t_empty_and_full();
    step(0, 0, 0, 1, 0, "R7 drain 1");
    step(0, 0, 0, 1, 0, "R7 drain 2");
    step(0, 0, 0, 1, 0, "R8 spurious done 1");
    step(0, 0, 0, 1, 0, "R8 spurious done 2");
    for (int k = 0; k < DEPTH; k++)
      step(1, 100 + 2 * k, 101 + 2 * k, 0, 1, "R8 fill accept");
    @(negedge clk);
    reqValid = 1; reqAddrA = 16'd500; reqAddrB = 16'd501; #1;
    chk("R6 full holds", issueValid, 1'b0);
    chk("R6 stallFull", stallFull, 1'b1);
    chk("R6 no conflict", stallConflict, 1'b0);
    chk("R10 depth ready low", reqReady, 1'b0);
    step(0, 0, 0, 1, 0, "R6 retire one");
    step(1, 500, 501, 0, 1, "R6 accept after room");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_pass();
        t_conflict();
        t_same_cycle_done();
        t_order();
        t_empty_and_full();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule